// File: doc/BRIEF.md
# Receive Flow-Control Line Driver with Hysteresis

This block drives the active-low request-to-send pin of a serial receiver. It watches how full the receive queue is and tells the far-end transmitter to stop before the queue overflows. When the queue has drained far enough, it tells the transmitter to start again. It takes four inputs: the queue occupancy count, the programmed receive trigger level, an enhanced-feature enable bit and the manual request bit from the modem-control register.

In automatic mode, the block derives two thresholds from the trigger level. The pause threshold is the trigger level plus a fixed margin, and the resume threshold is the trigger level minus the same margin. Both thresholds are clamped to the queue range. The pin goes high when occupancy reaches the pause threshold. It goes low when occupancy drains to the resume threshold. Between the two thresholds it keeps its last level, so it does not toggle on every character. When automatic mode is off, the pin is simply the inverse of the manual request bit.

Every port is a plain level signal with no valid/ready stream, so there is no back-pressure protocol. The pin comes from a single register and changes only on a clock edge.

Top module: `rts_flow_ctl`

## Requirements
- R1: While `rst_n` is low, `rts_n` is 1. It keeps that value until the first rising clock edge with `rst_n` high.
- R2: Automatic mode is active only when `feat_en` = 1 and `mcr_rts` = 1. Every other combination is manual mode, whatever the occupancy is.
- R3: In manual mode, `rts_n` takes the value of the inverse of `mcr_rts`.
- R4: In automatic mode, if `occupancy` is at or above the pause threshold, `rts_n` becomes 1. The pause threshold is min(effective trigger + 8, 64).
- R5: In automatic mode, if `occupancy` is at or below the resume threshold and below the pause threshold, `rts_n` becomes 0. The resume threshold is max(effective trigger − 8, 0).
- R6: In automatic mode, if `occupancy` is strictly between the two thresholds, `rts_n` keeps its previous value.
- R7: A `trig_level` above 64 is treated as 64. The effective trigger is therefore min(`trig_level`, 64).
- R8: `rts_n` is registered. A change on any input shows at `rts_n` after the next rising clock edge, and not before.
- R9: With `trig_level` = 16, `rts_n` goes to 1 when occupancy reaches 24. It returns to 0 when occupancy drains to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| occupancy | input | 7 | Current receive-queue fill count, 0..64 |
| trig_level | input | 7 | Programmed receive trigger level |
| feat_en | input | 1 | Enhanced-feature enable for automatic flow control |
| mcr_rts | input | 1 | Manual request bit (1 = request to send) |
| rts_n | output | 1 | Active-low request-to-send pin |

## Verification
Every result appears exactly one rising edge after the inputs that cause it. The bench drives inputs 2 ns after an edge and samples 2 ns after the following edge. For R8 it also samples just before that edge, to confirm that the old level still holds. Hysteresis checks step occupancy across each threshold from both sides. Each sample comes one edge after the step, so it tells a held level apart from a fresh decision.

// File: rtl/rts_fc_pkg.sv
package rts_fc_pkg;

  // Logical pin levels for the active-low request line
  localparam logic PIN_GO   = 1'b0;
  localparam logic PIN_STOP = 1'b1;

  typedef enum logic [1:0] {
    ZONE_LOW  = 2'd0,
    ZONE_BAND = 2'd1,
    ZONE_HIGH = 2'd2
  } occ_zone_e;

  // Saturating helpers on integer operands
  function automatic int sat_add(input int a, input int b, input int top);
    return (a + b > top) ? top : a + b;
  endfunction

  function automatic int sat_sub(input int a, input int b);
    return (a < b) ? 0 : a - b;
  endfunction

endpackage

// File: rtl/rts_fc_thresh.sv
module rts_fc_thresh #(
  parameter int DEPTH = 64,
  parameter int HYST  = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] trig,
  output logic [CW-1:0] thr_hi,
  output logic [CW-1:0] thr_lo
);
  import rts_fc_pkg::*;

  int eff_trig;

  always_comb begin
    eff_trig = (int'(trig) > DEPTH) ? DEPTH : int'(trig);
    thr_hi   = CW'(sat_add(eff_trig, HYST, DEPTH));
    thr_lo   = CW'(sat_sub(eff_trig, HYST));
  end
endmodule

// File: rtl/rts_fc_zone.sv
module rts_fc_zone #(
  parameter int CW = 7
) (
  input  logic [CW-1:0]         occ,
  input  logic [CW-1:0]         thr_hi,
  input  logic [CW-1:0]         thr_lo,
  output rts_fc_pkg::occ_zone_e zone
);
  import rts_fc_pkg::*;

  always_comb begin
    if (occ >= thr_hi)      zone = ZONE_HIGH;
    else if (occ <= thr_lo) zone = ZONE_LOW;
    else                    zone = ZONE_BAND;
  end
endmodule

// File: rtl/rts_flow_ctl.sv
module rts_flow_ctl #(
  parameter int DEPTH = 64,
  parameter int HYST  = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] occupancy,
  input  logic [CW-1:0] trig_level,
  input  logic          feat_en,
  input  logic          mcr_rts,
  output logic          rts_n
);
  import rts_fc_pkg::*;

  logic [CW-1:0] thr_hi, thr_lo;
  occ_zone_e     zone;
  logic          auto_on;
  logic          pin_nxt;

  rts_fc_thresh #(.DEPTH(DEPTH), .HYST(HYST), .CW(CW)) u_thresh (
    .trig   (trig_level),
    .thr_hi (thr_hi),
    .thr_lo (thr_lo)
  );

  rts_fc_zone #(.CW(CW)) u_zone (
    .occ    (occupancy),
    .thr_hi (thr_hi),
    .thr_lo (thr_lo),
    .zone   (zone)
  );

  assign auto_on = feat_en & mcr_rts;

  always_comb begin
    if (!auto_on) begin
      pin_nxt = ~mcr_rts;
    end else begin
      unique case (zone)
        ZONE_HIGH: pin_nxt = PIN_STOP;
        ZONE_LOW:  pin_nxt = PIN_GO;
        default:   pin_nxt = rts_n;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rts_n <= PIN_STOP;
    else        rts_n <= pin_nxt;
  end

  AST_RESET_STOP: assert property (@(posedge clk) !rst_n |=> rts_n); // R1
  AST_MANUAL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !(feat_en && mcr_rts) |=> rts_n == !$past(mcr_rts)); // R3
  AST_PAUSE_AT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && mcr_rts && occupancy >= thr_hi) |=> rts_n); // R4
  AST_RESUME_AT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && mcr_rts && occupancy <= thr_lo && occupancy < thr_hi) |=> !rts_n); // R5
  AST_HOLD_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_en && mcr_rts && occupancy > thr_lo && occupancy < thr_hi) |=> $stable(rts_n)); // R6
  AST_THRESH_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_hi > thr_lo) && (int'(thr_hi) <= DEPTH)); // R7
endmodule

// File: tb/test_rts_flow_ctl.sv
`timescale 1ns/1ps
module test_rts_flow_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] occupancy = '0;
  logic [6:0] trig_level = '0;
  logic       feat_en = 1'b0;
  logic       mcr_rts = 1'b0;
  logic       rts_n;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  rts_flow_ctl i_rts_flow_ctl (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .trig_level(trig_level),
    .feat_en(feat_en), .mcr_rts(mcr_rts), .rts_n(rts_n)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic exp);
    total++;
    if (rts_n !== exp) begin
      bad++;
      $display("FAIL %s: rts_n=%b expected=%b (occ=%0d trig=%0d)", req, rts_n, exp, occupancy, trig_level);
    end
  endtask

  task automatic set_occ_chk(input int occ, input string req, input logic exp);
    occupancy = 7'(occ);
    step();
    chk(req, exp);
  endtask

  task automatic t_reset();
    feat_en = 1'b0; mcr_rts = 1'b1;
    step(); chk("R1", 1'b1);
    step(); chk("R1", 1'b1);
    rst_n = 1'b1;
    #5; chk("R1", 1'b1);
    step(); chk("R3", 1'b0);
  endtask

  task automatic t_manual();
    mcr_rts = 1'b0; step(); chk("R3", 1'b1);
    mcr_rts = 1'b1; step(); chk("R3", 1'b0);
    feat_en = 1'b1; mcr_rts = 1'b0; occupancy = 7'd0; trig_level = 7'd16;
    step(); chk("R2", 1'b1);
    feat_en = 1'b0; mcr_rts = 1'b1; occupancy = 7'd64;
    step(); chk("R2", 1'b0);
  endtask

  task automatic t_trig16();
    feat_en = 1'b1; mcr_rts = 1'b1; trig_level = 7'd16;
    set_occ_chk(0,  "R5", 1'b0);
    set_occ_chk(23, "R6", 1'b0);
    occupancy = 7'd24;
    #15; chk("R8", 1'b0);
    @(posedge clk); #2; chk("R9", 1'b1);
    set_occ_chk(23, "R6", 1'b1);
    set_occ_chk(9,  "R6", 1'b1);
    set_occ_chk(8,  "R9", 1'b0);
    set_occ_chk(16, "R6", 1'b0);
  endtask

  task automatic t_low_clamp();
    trig_level = 7'd4;
    set_occ_chk(11, "R6", 1'b0);
    set_occ_chk(12, "R4", 1'b1);
    set_occ_chk(1,  "R5", 1'b1);
    set_occ_chk(0,  "R5", 1'b0);
  endtask

  task automatic t_high_clamp();
    trig_level = 7'd60;
    set_occ_chk(63, "R4", 1'b0);
    set_occ_chk(64, "R4", 1'b1);
    set_occ_chk(53, "R5", 1'b1);
    set_occ_chk(52, "R5", 1'b0);
    trig_level = 7'd100;
    set_occ_chk(64, "R7", 1'b1);
    set_occ_chk(57, "R7", 1'b1);
    set_occ_chk(56, "R7", 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    bad++; total++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_manual();
    t_trig16();
    t_low_clamp();
    t_high_clamp();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule